// File: doc/BRIEF.md
# Key-Guarded Watchdog Timer

This block is a watchdog whose only software controls are magic values written to one key register. A slow tick input is divided by a selectable power of two. Each divided tick steps a 12-bit down-counter. When the counter runs out, the block raises a single-cycle reset request and reloads. Software keeps the system alive by writing the feed key often enough. It changes the division and the reload value only after an unlock key. Once started, nothing short of a block reset stops the counter.

The bus is a plain single-cycle write strobe with a 4-bit byte address and 32-bit data. Read data is driven combinationally from the current address. A new divider or reload value does not act at once. It is held in a shadow and committed a fixed number of raw ticks after the write. A status flag for each register stays high while that commit is pending.

Top module: `kwdog_top`

## Requirements
- R1: After reset the divider register reads 0, the reload register reads 0xFFF, status reads 0, the counter is stopped and `rst_req` is low.
- R2: `bus_addr[3:2]` selects the register. Index 0 is the key register and always reads 0. Index 1 is the divider code in bits [2:0]. Index 2 is the reload value in bits [11:0]. Index 3 is status, with bit 0 for a divider update and bit 1 for a reload update. All other read bits are 0.
- R3: Writes to the divider or reload register are ignored unless the most recent key write carried 0x5555 in `bus_wdata[15:0]`.
- R4: A key write with any other value in bits [15:0] locks configuration again. This includes the start key 0xCCCC and the feed key 0xAAAA.
- R5: Key 0xCCCC starts the counter from the committed reload value and clears the divider phase. Before the first start, `rst_req` never rises, whatever the ticks do.
- R6: With committed reload N and division D, the first `rst_req` comes N+1 divided ticks after start, which is (N+1)*D raw ticks. The pulse lasts one clock and appears in the clock after the tick that completes the count. The counter then reloads, so pulses repeat every (N+1)*D ticks.
- R7: Key 0xAAAA reloads the counter from the committed reload value. It does not reset the divider phase, so the next expiry comes between N*D+1 and (N+1)*D ticks later.
- R8: Divider codes 0 to 5 divide by 4, 8, 16, 32, 64 and 128. Codes 6 and 7 both divide by 256.
- R9: An accepted write to the divider or reload register sets its status flag. The flag clears, and the new value takes effect, on the 3rd raw tick after the write (parameter UPD_TICKS). Another write to the same register while the flag is set restarts that count.
- R10: Once started, the counter cannot be stopped by any key write. Only reset clears the running state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counting clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| tick | input | 1 | Slow time base, one-cycle pulse per tick |
| bus_wr | input | 1 | Write strobe, one write per asserted cycle |
| bus_addr | input | 4 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address |
| rst_req | output | 1 | One-cycle reset request on expiry |

## Verification
The assertions take for granted that `tick` is already a clean single-cycle pulse in the `clk` domain. They also assume at most one bus write per cycle, and that the dividers never allow two divided ticks in adjacent cycles. The single-cycle `rst_req` property relies on that last point. The stimulus raises `tick` for one cycle at a time with an idle cycle after it, and holds ticks low during every bus write. As a result, each measured expiry period can be counted exactly in ticks.

// File: rtl/kwdog_pkg.sv
package kwdog_pkg;
    localparam int BUS_AW       = 4;
    localparam int DATA_W       = 32;
    localparam int KEY_W        = 16;
    localparam int RLD_W        = 12;
    localparam int PSC_W        = 3;
    localparam int DIV_LOG_MIN  = 2;
    localparam int PSC_CODE_CAP = 6;
    localparam int PCNT_W       = DIV_LOG_MIN + PSC_CODE_CAP;

    localparam logic [KEY_W-1:0] KEY_OPEN  = 16'h5555;
    localparam logic [KEY_W-1:0] KEY_START = 16'hCCCC;
    localparam logic [KEY_W-1:0] KEY_FEED  = 16'hAAAA;

    typedef enum logic [1:0] {
        REG_KEY = 2'd0,
        REG_PSC = 2'd1,
        REG_RLD = 2'd2,
        REG_STS = 2'd3
    } reg_idx_e;

    // Last value of the divider phase counter for a given code.
    function automatic logic [PCNT_W-1:0] div_last(input logic [PSC_W-1:0] code);
        int lg;
        lg = DIV_LOG_MIN + ((int'(code) > PSC_CODE_CAP) ? PSC_CODE_CAP : int'(code));
        return PCNT_W'((1 << lg) - 1);
    endfunction
endpackage

// File: rtl/kwdog_shadow.sv
module kwdog_shadow #(
    parameter int          W         = 12,
    parameter int          UPD_TICKS = 3,
    parameter logic [W-1:0] RST_VAL  = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         load,
    input  logic [W-1:0] val,
    output logic         pend,
    output logic [W-1:0] eff
);
    localparam int CD_W = $clog2(UPD_TICKS + 1);

    typedef struct packed {
        logic            pend;
        logic [CD_W-1:0] cd;
        logic [W-1:0]    eff;
    } sh_st_t;

    sh_st_t sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (load) begin
            sh_d.pend = 1'b1;
            sh_d.cd   = CD_W'(UPD_TICKS);
        end else if (sh_q.pend && tick) begin
            if (sh_q.cd == CD_W'(1)) begin
                sh_d.pend = 1'b0;
                sh_d.eff  = val;
            end else begin
                sh_d.cd = sh_q.cd - CD_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q.pend <= 1'b0;
            sh_q.cd   <= '0;
            sh_q.eff  <= RST_VAL;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign pend = sh_q.pend;
    assign eff  = sh_q.eff;
endmodule

// File: rtl/kwdog_cfg.sv
module kwdog_cfg
    import kwdog_pkg::*;
#(
    parameter int UPD_TICKS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              bus_wr,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              unl,
    output logic              key_start,
    output logic              key_feed,
    output logic [PSC_W-1:0]  psc_reg,
    output logic [PSC_W-1:0]  psc_eff,
    output logic [RLD_W-1:0]  rld_eff,
    output logic              pvu,
    output logic              rvu
);
    typedef struct packed {
        logic             unl;
        logic [PSC_W-1:0] psc;
        logic [RLD_W-1:0] rld;
    } cfg_st_t;

    cfg_st_t  cf_d, cf_q;
    reg_idx_e sel;
    logic [KEY_W-1:0] key;
    logic wr_key, wr_psc, wr_rld;
    logic unused_hi;

    assign sel       = reg_idx_e'(bus_addr[3:2]);
    assign key       = bus_wdata[KEY_W-1:0];
    assign unused_hi = &{1'b0, bus_wdata[DATA_W-1:KEY_W], bus_addr[1:0]};

    always_comb begin
        cf_d      = cf_q;
        wr_key    = bus_wr && (sel == REG_KEY);
        wr_psc    = bus_wr && (sel == REG_PSC) && cf_q.unl;
        wr_rld    = bus_wr && (sel == REG_RLD) && cf_q.unl;
        key_start = wr_key && (key == KEY_START);
        key_feed  = wr_key && (key == KEY_FEED);
        if (wr_key) begin
            cf_d.unl = (key == KEY_OPEN);
        end
        if (wr_psc) begin
            cf_d.psc = bus_wdata[PSC_W-1:0];
        end
        if (wr_rld) begin
            cf_d.rld = bus_wdata[RLD_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cf_q.unl <= 1'b0;
            cf_q.psc <= '0;
            cf_q.rld <= '1;
        end else begin
            cf_q <= cf_d;
        end
    end

    kwdog_shadow #(.W(PSC_W), .UPD_TICKS(UPD_TICKS), .RST_VAL('0)) u_psc_sh (
        .clk (clk),
        .rst_n(rst_n),
        .tick(tick),
        .load(wr_psc),
        .val (cf_q.psc),
        .pend(pvu),
        .eff (psc_eff)
    );

    kwdog_shadow #(.W(RLD_W), .UPD_TICKS(UPD_TICKS), .RST_VAL('1)) u_rld_sh (
        .clk (clk),
        .rst_n(rst_n),
        .tick(tick),
        .load(wr_rld),
        .val (cf_q.rld),
        .pend(rvu),
        .eff (rld_eff)
    );

    always_comb begin
        case (sel)
            REG_PSC: bus_rdata = DATA_W'(cf_q.psc);
            REG_RLD: bus_rdata = DATA_W'(cf_q.rld);
            REG_STS: bus_rdata = DATA_W'({rvu, pvu});
            default: bus_rdata = '0;
        endcase
    end

    assign unl     = cf_q.unl;
    assign psc_reg = cf_q.psc;
endmodule

// File: rtl/kwdog_presc.sv
module kwdog_presc
    import kwdog_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clear,
    input  logic             tick,
    input  logic [PSC_W-1:0] code,
    output logic             ptick
);
    typedef struct packed {
        logic [PCNT_W-1:0] cnt;
    } ps_st_t;

    ps_st_t ps_d, ps_q;

    always_comb begin
        ps_d  = ps_q;
        ptick = 1'b0;
        if (clear) begin
            ps_d.cnt = '0;
        end else if (run && tick) begin
            if (ps_q.cnt >= div_last(code)) begin
                ps_d.cnt = '0;
                ptick    = 1'b1;
            end else begin
                ps_d.cnt = ps_q.cnt + PCNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ps_q.cnt <= '0;
        end else begin
            ps_q <= ps_d;
        end
    end
endmodule

// File: rtl/kwdog_count.sv
module kwdog_count
    import kwdog_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             feed,
    input  logic             ptick,
    input  logic [RLD_W-1:0] reload,
    output logic             run,
    output logic             req
);
    typedef struct packed {
        logic             run;
        logic [RLD_W-1:0] cnt;
        logic             req;
    } ct_st_t;

    ct_st_t ct_d, ct_q;

    always_comb begin
        ct_d     = ct_q;
        ct_d.req = 1'b0;
        if (start || feed) begin
            ct_d.cnt = reload;
            if (start) begin
                ct_d.run = 1'b1;
            end
        end else if (ptick && ct_q.run) begin
            if (ct_q.cnt == '0) begin
                ct_d.req = 1'b1;
                ct_d.cnt = reload;
            end else begin
                ct_d.cnt = ct_q.cnt - RLD_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ct_q.run <= 1'b0;
            ct_q.cnt <= '1;
            ct_q.req <= 1'b0;
        end else begin
            ct_q <= ct_d;
        end
    end

    assign run = ct_q.run;
    assign req = ct_q.req;
endmodule

// File: rtl/kwdog_top.sv
module kwdog_top
    import kwdog_pkg::*;
#(
    parameter int UPD_TICKS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              bus_wr,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              rst_req
);
    logic             cfg_unl;
    logic             key_start;
    logic             key_feed;
    logic [PSC_W-1:0] psc_reg;
    logic [PSC_W-1:0] psc_eff;
    logic [RLD_W-1:0] rld_eff;
    logic             upd_psc;
    logic             upd_rld;
    logic             cnt_run;
    logic             pre_tick;

    kwdog_cfg #(.UPD_TICKS(UPD_TICKS)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .unl      (cfg_unl),
        .key_start(key_start),
        .key_feed (key_feed),
        .psc_reg  (psc_reg),
        .psc_eff  (psc_eff),
        .rld_eff  (rld_eff),
        .pvu      (upd_psc),
        .rvu      (upd_rld)
    );

    kwdog_presc u_presc (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (cnt_run),
        .clear(key_start && !cnt_run),
        .tick (tick),
        .code (psc_eff),
        .ptick(pre_tick)
    );

    kwdog_count u_count (
        .clk   (clk),
        .rst_n (rst_n),
        .start (key_start),
        .feed  (key_feed),
        .ptick (pre_tick),
        .reload(rld_eff),
        .run   (cnt_run),
        .req   (rst_req)
    );
endmodule

// File: rtl/kwdog_chk.sv
module kwdog_chk
    import kwdog_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              bus_wr,
    input logic [BUS_AW-1:0] bus_addr,
    input logic [KEY_W-1:0]  key,
    input logic              rst_req,
    input logic              run,
    input logic              unl,
    input logic [PSC_W-1:0]  psc_reg,
    input logic              pvu,
    input logic              ptick
);
    logic is_key, is_psc;
    assign is_key = bus_wr && (bus_addr[3:2] == REG_KEY);
    assign is_psc = bus_wr && (bus_addr[3:2] == REG_PSC);

    assert_req_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    assert_no_req_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !rst_req);

    assert_run_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> run);

    assert_locked_psc_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!unl && is_psc) |=> $stable(psc_reg));

    assert_relock_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (is_key && key != KEY_OPEN) |=> !unl);

    assert_psc_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (unl && is_psc) |=> pvu);

    assert_ptick_from_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ptick |-> tick);
endmodule

bind kwdog_top kwdog_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .bus_wr  (bus_wr),
    .bus_addr(bus_addr),
    .key     (bus_wdata[15:0]),
    .rst_req (rst_req),
    .run     (cnt_run),
    .unl     (cfg_unl),
    .psc_reg (psc_reg),
    .pvu     (upd_psc),
    .ptick   (pre_tick)
);

// File: tb/test_kwdog_top.sv
`timescale 1ns/1ps
module test_kwdog_top;
    localparam int UPD = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = 4'h0;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        rst_req;

    int checks = 0;
    int errors = 0;
    int req_cnt = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    kwdog_top #(.UPD_TICKS(UPD)) i_kwdog_top (
        .clk(clk), .rst_n(rst_n), .tick(tick), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .rst_req(rst_req)
    );

    // ---------------- behavioural reference ----------------
    int m_unl, m_run, m_pc, m_rl, m_pce, m_rle, m_pvu, m_rvu, m_pcd, m_rcd;
    int m_ph, m_cnt, m_req;

    function automatic int div_of(int code);
        return (code >= 6) ? 256 : (4 << code);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_unl = 0; m_run = 0; m_pc = 0; m_rl = 'hFFF; m_pce = 0; m_rle = 'hFFF;
            m_pvu = 0; m_rvu = 0; m_pcd = 0; m_rcd = 0; m_ph = 0; m_cnt = 'hFFF; m_req = 0;
        end else begin
            int n_unl, n_run, n_pc, n_rl, n_pce, n_rle, n_pvu, n_rvu, n_pcd, n_rcd, n_ph, n_cnt, n_req;
            int idx, k, pt;
            n_unl = m_unl; n_run = m_run; n_pc = m_pc; n_rl = m_rl; n_pce = m_pce; n_rle = m_rle;
            n_pvu = m_pvu; n_rvu = m_rvu; n_pcd = m_pcd; n_rcd = m_rcd; n_ph = m_ph; n_cnt = m_cnt;
            n_req = 0; pt = 0;
            idx = int'(bus_addr[3:2]);
            k = int'(bus_wdata[15:0]);
            if (bus_wr && idx == 0) n_unl = (k == 'h5555) ? 1 : 0;
            if (bus_wr && idx == 1 && m_unl == 1) begin
                n_pc = int'(bus_wdata[2:0]); n_pvu = 1; n_pcd = UPD;
            end else if (m_pvu == 1 && tick) begin
                if (m_pcd == 1) begin n_pvu = 0; n_pce = m_pc; end else n_pcd = m_pcd - 1;
            end
            if (bus_wr && idx == 2 && m_unl == 1) begin
                n_rl = int'(bus_wdata[11:0]); n_rvu = 1; n_rcd = UPD;
            end else if (m_rvu == 1 && tick) begin
                if (m_rcd == 1) begin n_rvu = 0; n_rle = m_rl; end else n_rcd = m_rcd - 1;
            end
            if (m_run == 1 && tick) begin
                if (m_ph >= div_of(m_pce) - 1) begin n_ph = 0; pt = 1; end else n_ph = m_ph + 1;
            end
            if (bus_wr && idx == 0 && (k == 'hCCCC || k == 'hAAAA)) begin
                n_cnt = m_rle;
                if (k == 'hCCCC && m_run == 0) begin n_run = 1; n_ph = 0; end
            end else if (pt == 1) begin
                if (m_cnt == 0) begin n_req = 1; n_cnt = m_rle; end else n_cnt = m_cnt - 1;
            end
            m_unl = n_unl; m_run = n_run; m_pc = n_pc; m_rl = n_rl; m_pce = n_pce; m_rle = n_rle;
            m_pvu = n_pvu; m_rvu = n_rvu; m_pcd = n_pcd; m_rcd = n_rcd; m_ph = n_ph; m_cnt = n_cnt;
            m_req = n_req;
        end
    end

    function automatic int m_read(logic [3:0] a);
        case (a[3:2])
            2'd1: return m_pc;
            2'd2: return m_rl;
            2'd3: return m_rvu * 2 + m_pvu;
            default: return 0;
        endcase
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // continuous comparison against the model, every clock
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R2 read data vs model", int'(bus_rdata), m_read(bus_addr));
            chk("R6 rst_req vs model", int'(rst_req), m_req);
            if (rst_req) req_cnt++;
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic cyc(input logic t, input logic w, input logic [3:0] a, input logic [31:0] d);
        @(posedge clk);
        #1;
        tick = t; bus_wr = w; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        #0.1;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        cyc(1'b0, 1'b1, a, d);
    endtask

    task automatic rd_chk(input string tag, input logic [3:0] a, input int exp);
        cyc(1'b0, 1'b0, a, 32'h0);
        chk(tag, int'(bus_rdata), exp);
    endtask

    task automatic do_tick();
        cyc(1'b1, 1'b0, 4'h0, 32'h0);
        cyc(1'b0, 1'b0, 4'h0, 32'h0);
    endtask

    task automatic wait_req(output int n);
        int base;
        base = req_cnt;
        n = 0;
        while (req_cnt == base && n < 3000) begin
            do_tick();
            n++;
        end
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog expired actual hung expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int n, base;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd_chk("R1 divider after reset", 4'h4, 0);
        rd_chk("R1 reload after reset", 4'h8, 'hFFF);
        rd_chk("R1 status after reset", 4'hC, 0);
        chk("R1 rst_req after reset", int'(rst_req), 0);
        wr(4'h0, 32'h0000_1234);
        rd_chk("R2 key reads zero", 4'h0, 0);

        // R3 locked writes ignored
        wr(4'h4, 32'h5);
        wr(4'h8, 32'h5);
        rd_chk("R3 locked divider write ignored", 4'h4, 0);
        rd_chk("R3 locked reload write ignored", 4'h8, 'hFFF);
        rd_chk("R3 no status after locked writes", 4'hC, 0);

        // R9 unlocked writes, status flags and commit
        wr(4'h0, 32'hFFFF_5555);
        wr(4'h4, 32'h0);
        rd_chk("R9 divider flag set", 4'hC, 1);
        wr(4'h8, 32'h3);
        rd_chk("R9 both flags set", 4'hC, 3);
        rd_chk("R2 reload readback", 4'h8, 3);
        do_tick(); do_tick();
        rd_chk("R9 flags held before commit", 4'hC, 3);
        do_tick();
        rd_chk("R9 flags clear after commit", 4'hC, 0);

        // R4 relock by feed key and by an arbitrary key
        wr(4'h0, 32'h5555);
        wr(4'h0, 32'hAAAA);
        wr(4'h8, 32'h9);
        rd_chk("R4 relocked by feed key", 4'h8, 3);
        wr(4'h0, 32'h5555);
        wr(4'h0, 32'h1234);
        wr(4'h4, 32'h3);
        rd_chk("R4 relocked by other key", 4'h4, 0);

        // R5 idle: no request
        base = req_cnt;
        repeat (40) do_tick();
        chk("R5 no request before start", req_cnt - base, 0);

        // R6 start and periodic expiry: (3+1)*4 = 16 ticks
        wr(4'h0, 32'h5555);
        wr(4'h0, 32'hCCCC);
        wr(4'h8, 32'h9);
        rd_chk("R4 relocked by start key", 4'h8, 3);
        wait_req(n);
        chk("R6 first expiry ticks", n, 16);
        wait_req(n);
        chk("R6 repeat expiry ticks", n, 16);

        // R7 feeding postpones
        base = req_cnt;
        for (int i = 0; i < 6; i++) begin
            repeat (10) do_tick();
            wr(4'h0, 32'hAAAA);
        end
        chk("R7 no request while fed", req_cnt - base, 0);
        wait_req(n);
        chk("R7 expiry after feed in window", int'(n >= 13 && n <= 16), 1);

        // R10 no key stops it
        wr(4'h0, 32'h0000);
        wr(4'h0, 32'hFFFF);
        wait_req(n);
        chk("R10 still expires after other keys", n, 16);

        // R8 divider codes
        wr(4'h0, 32'h5555);
        wr(4'h4, 32'h7);
        wr(4'h8, 32'h1);
        wait_req(n);
        wait_req(n);
        chk("R8 code 7 divides by 256", n, 512);
        wr(4'h0, 32'h5555);
        wr(4'h4, 32'h6);
        wait_req(n);
        wait_req(n);
        chk("R8 code 6 divides by 256", n, 512);
        wr(4'h0, 32'h5555);
        wr(4'h4, 32'h2);
        wr(4'h8, 32'h0);
        wait_req(n);
        wait_req(n);
        chk("R8 code 2 divides by 16", n, 16);
        wr(4'h0, 32'h5555);
        wr(4'h4, 32'h5);
        wr(4'h8, 32'h2);
        wait_req(n);
        wait_req(n);
        chk("R8 code 5 divides by 128", n, 384);

        // R9 rewrite restarts the commit count
        wr(4'h0, 32'h5555);
        wr(4'h8, 32'h7);
        do_tick(); do_tick();
        wr(4'h8, 32'h6);
        do_tick(); do_tick();
        rd_chk("R9 rewrite restarts count", 4'hC, 2);
        do_tick();
        rd_chk("R9 rewrite commits", 4'hC, 0);

        cyc(1'b0, 1'b0, 4'h0, 32'h0);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule